// File: doc/BRIEF.md
# Quadrature / Up-Down Position Counter with Wrap Hysteresis Flags

This block keeps a position count from an incremental encoder. A mode input picks the decoding. In quadrature mode, tracks A and B are decoded four-fold: every edge on either track moves the count by one. In pulse mode, only rising edges of track A count, and track B sets the direction. A reverse input inverts the direction in both modes. A gate input with selectable active level freezes the count. Edges that arrive while the gate is active are discarded. In quadrature mode, a sample in which both tracks change at once is rejected and reported.

Wraparound is latched in two sticky flags, and each flag clears with hysteresis. The overflow flag is set when the count wraps from all-ones to zero. It clears only after the count has climbed past one third of the range. The underflow flag is set when the count wraps from zero to all-ones. It clears only after the count has fallen below two thirds of the range. This keeps the flags steady while a shaft jitters around the wrap point. While any counter reset source is enabled elsewhere, the `rst_src_en` input forces both flags low and stops them from being set. A clear pulse and a load port let the surrounding logic set the count.

The track and gate inputs pass through a synchronizer inside the block. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `quad_pos_counter`

## Requirements
- R1: With `mode_updn`=0 and `dir_rev`=0, the state {A,B} sequence 00→10→11→01→00 (A leading) increments the count once per transition, and the reverse sequence decrements it once per transition.
- R2: With `mode_updn`=1, only a rising edge of A changes the count: by +1 when B is 0 and by −1 when B is 1. Changes of B alone and falling edges of A leave the count unchanged.
- R3: With `dir_rev`=1, every counting step in either mode goes in the opposite direction. Changing `dir_rev` alone does not change the count.
- R4: The gate is active when the synchronized `gate_in` equals `gate_pol`. While it is active the count holds, and track edges seen during that time are not counted later.
- R5: In quadrature mode with the gate open, a sample in which A and B both change leaves the count unchanged and raises `quad_err` for exactly one cycle. `quad_err` never rises in pulse mode.
- R6: A step up from all-ones to zero sets `ovf_flag`. The flag stays set while the count is at or below floor(MAX/3).
- R7: A set `ovf_flag` clears once the count is above floor(MAX/3).
- R8: A step down from zero to all-ones sets `unf_flag`. The flag stays set while the count is at or above floor(2·MAX/3).
- R9: A set `unf_flag` clears once the count is below floor(2·MAX/3).
- R10: While `rst_src_en`=1, both flags are forced to 0 and a wrap does not set them. After `rst_src_en` returns to 0, a flag is not set again until a new wrap occurs.
- R11: `clr` loads zero and takes priority over `load_en`. `load_en` loads `load_val`. Neither sets a flag. Both take effect on the next clock edge.
- R12: While reset is asserted, the count, both flags and `quad_err` are 0. A change on a track input shows in the count on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trk_a | input | 1 | Encoder track A / count pulse input |
| trk_b | input | 1 | Encoder track B / direction input in pulse mode |
| gate_in | input | 1 | Gate input (asynchronous) |
| gate_pol | input | 1 | Level of `gate_in` that freezes the count |
| mode_updn | input | 1 | 0 = four-fold quadrature, 1 = pulse with direction |
| dir_rev | input | 1 | Inverts the counting direction |
| rst_src_en | input | 1 | A counter reset source is enabled; disables the wrap flags |
| load_en | input | 1 | Load `load_val` into the count |
| load_val | input | CNT_W | Value to load |
| clr | input | 1 | Clear the count to zero |
| count | output | CNT_W | Current position count |
| ovf_flag | output | 1 | Sticky overflow flag with hysteresis |
| unf_flag | output | 1 | Sticky underflow flag with hysteresis |
| quad_err | output | 1 | One-cycle pulse on an illegal quadrature transition |

## Verification
The hysteresis thresholds are the hardest states to reach from the ports. Reaching a third of a 16-bit range by counting edges would take tens of thousands of encoder steps. The stimulus therefore uses the load port to place the count right at each wrap point and on either side of each threshold. Single encoder steps then cause the wraps. For the gate and reversal cases, the bench drives the tracks in the exact orders that would have counted if the gate were open or the reverse bit were clear.

// File: rtl/quad_cnt_pkg.sv
package quad_cnt_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DN   = 2'b10
  } step_e;
endpackage

// File: rtl/qc_rst_sync.sv
module qc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/qc_input_sync.sv
module qc_input_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qc_step_decoder.sv
module qc_step_decoder
  import quad_cnt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a_s,
  input  logic  b_s,
  input  logic  gate_act,
  input  logic  mode_updn,
  input  logic  dir_rev,
  output step_e step,
  output logic  illegal
);
  logic [1:0] prev_q;
  logic [1:0] prev_d;
  logic       raw_up;
  logic       raw_dn;
  logic       raw_bad;

  // Previous sample always follows the tracks, so gated edges are dropped.
  assign prev_d = {a_s, b_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= prev_d;
  end

  always_comb begin
    raw_up  = 1'b0;
    raw_dn  = 1'b0;
    raw_bad = 1'b0;
    if (mode_updn) begin
      if (a_s && !prev_q[1]) begin
        raw_up = !b_s;
        raw_dn = b_s;
      end
    end else begin
      unique case ({prev_q, a_s, b_s})
        4'b0010, 4'b1011, 4'b1101, 4'b0100: raw_up  = 1'b1;
        4'b0001, 4'b0111, 4'b1110, 4'b1000: raw_dn  = 1'b1;
        4'b0011, 4'b1100, 4'b0110, 4'b1001: raw_bad = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    step    = STEP_NONE;
    illegal = 1'b0;
    if (!gate_act) begin
      illegal = raw_bad;
      if (raw_up)      step = dir_rev ? STEP_DN : STEP_UP;
      else if (raw_dn) step = dir_rev ? STEP_UP : STEP_DN;
    end
  end
endmodule

// File: rtl/qc_counter_core.sv
module qc_counter_core
  import quad_cnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step,
  input  logic             illegal,
  input  logic             clr,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             rst_src_en,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             unf_flag,
  output logic             quad_err
);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] ONE_THIRD = CNT_MAX / CNT_W'(3);
  localparam logic [CNT_W:0]   TWO_X     = {CNT_MAX, 1'b0};
  localparam logic [CNT_W:0]   TWO_T_EXT = TWO_X / (CNT_W+1)'(3);
  localparam logic [CNT_W-1:0] TWO_THIRD = TWO_T_EXT[CNT_W-1:0];

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             unf_q, unf_d;
  logic             err_q, err_d;
  logic             wrap_up, wrap_dn;

  always_comb begin
    cnt_d   = cnt_q;
    wrap_up = 1'b0;
    wrap_dn = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (load_en) begin
      cnt_d = load_val;
    end else if (step == STEP_UP) begin
      cnt_d   = cnt_q + CNT_W'(1);
      wrap_up = (cnt_q == CNT_MAX);
    end else if (step == STEP_DN) begin
      cnt_d   = cnt_q - CNT_W'(1);
      wrap_dn = (cnt_q == '0);
    end
  end

  always_comb begin
    if (rst_src_en)                       ovf_d = 1'b0;
    else if (wrap_up)                     ovf_d = 1'b1;
    else if (ovf_q && cnt_q > ONE_THIRD)  ovf_d = 1'b0;
    else                                  ovf_d = ovf_q;

    if (rst_src_en)                       unf_d = 1'b0;
    else if (wrap_dn)                     unf_d = 1'b1;
    else if (unf_q && cnt_q < TWO_THIRD)  unf_d = 1'b0;
    else                                  unf_d = unf_q;

    err_d = illegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
      err_q <= err_d;
    end
  end

  assign count    = cnt_q;
  assign ovf_flag = ovf_q;
  assign unf_flag = unf_q;
  assign quad_err = err_q;
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import quad_cnt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trk_a,
  input  logic             trk_b,
  input  logic             gate_in,
  input  logic             gate_pol,
  input  logic             mode_updn,
  input  logic             dir_rev,
  input  logic             rst_src_en,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             unf_flag,
  output logic             quad_err
);
  localparam int N_SYNC = 3;

  logic              rst_n_sync;
  logic [N_SYNC-1:0] raw_in;
  logic [N_SYNC-1:0] sync_in;
  logic              gate_act;
  step_e             step;
  logic              illegal;

  qc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign raw_in = {gate_in, trk_b, trk_a};

  qc_input_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .din   (raw_in),
    .dout  (sync_in)
  );

  assign gate_act = (sync_in[2] == gate_pol);

  qc_step_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .a_s       (sync_in[0]),
    .b_s       (sync_in[1]),
    .gate_act  (gate_act),
    .mode_updn (mode_updn),
    .dir_rev   (dir_rev),
    .step      (step),
    .illegal   (illegal)
  );

  qc_counter_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .step       (step),
    .illegal    (illegal),
    .clr        (clr),
    .load_en    (load_en),
    .load_val   (load_val),
    .rst_src_en (rst_src_en),
    .count      (count),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag),
    .quad_err   (quad_err)
  );
endmodule

// File: rtl/quad_pos_counter_chk.sv
module quad_pos_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n_sync,
  input logic             gate_act,
  input logic             mode_updn,
  input logic             rst_src_en,
  input logic             load_en,
  input logic             clr,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             unf_flag,
  input logic             quad_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R1: without clear or load the count moves by at most one per cycle
  p_single_step_r1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!$past(clr) && !$past(load_en)) |->
      (count == $past(count) || count == CNT_W'($past(count) + 1'b1) ||
       count == CNT_W'($past(count) - 1'b1)));

  // R4: an active gate freezes the count
  p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($past(gate_act) && !$past(clr) && !$past(load_en)) |-> $stable(count));

  // R5: error pulses only follow a quadrature-mode cycle with the gate open
  p_err_quad_only_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    quad_err |-> (!$past(mode_updn) && !$past(gate_act)));

  // R5: an error pulse lasts one cycle
  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    quad_err |=> !quad_err);

  // R6: wrap from all-ones to zero sets overflow
  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($past(count) == CNT_MAX && count == '0 && !$past(clr) && !$past(load_en)
     && !$past(rst_src_en)) |-> ovf_flag);

  // R8: wrap from zero to all-ones sets underflow
  p_unf_set_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($past(count) == '0 && count == CNT_MAX && !$past(clr) && !$past(load_en)
     && !$past(rst_src_en)) |-> unf_flag);

  // R10: reset source enabled forces the flags low
  p_flags_off_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $past(rst_src_en) |-> (!ovf_flag && !unf_flag));

  // R11: clear wins and yields zero
  p_clr_zero_r11: assert property (@(posedge clk) disable iff (!rst_n_sync)
    clr |=> (count == '0));
endmodule

bind quad_pos_counter quad_pos_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .gate_act   (gate_act),
  .mode_updn  (mode_updn),
  .rst_src_en (rst_src_en),
  .load_en    (load_en),
  .clr        (clr),
  .count      (count),
  .ovf_flag   (ovf_flag),
  .unf_flag   (unf_flag),
  .quad_err   (quad_err)
);

// File: tb/quad_pos_counter_test.sv
`timescale 1ns/1ps
module quad_pos_counter_test;
  localparam int W = 16;
  localparam int NV = 27;

  logic clk = 1'b0;
  logic rst_n, trk_a, trk_b, gate_in, gate_pol, mode_updn, dir_rev;
  logic rst_src_en, load_en, clr;
  logic [W-1:0] load_val;
  logic [W-1:0] count;
  logic ovf_flag, unf_flag, quad_err;

  int n_chk = 0;
  int n_fail = 0;
  int err_pulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  quad_pos_counter #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .trk_a(trk_a), .trk_b(trk_b),
    .gate_in(gate_in), .gate_pol(gate_pol), .mode_updn(mode_updn),
    .dir_rev(dir_rev), .rst_src_en(rst_src_en), .load_en(load_en),
    .load_val(load_val), .clr(clr), .count(count), .ovf_flag(ovf_flag),
    .unf_flag(unf_flag), .quad_err(quad_err)
  );

  always @(negedge clk) if (quad_err === 1'b1) err_pulses++;

  // entry: [29:26] requirement, [21:16] {mode,rev,gpol,gate,a,b}, [15:0] expected count
  localparam logic [29:0] VEC [NV] = '{
    {4'd1,  4'd0, 6'b001000, 16'd0},
    {4'd1,  4'd0, 6'b001010, 16'd1},
    {4'd1,  4'd0, 6'b001011, 16'd2},
    {4'd1,  4'd0, 6'b001001, 16'd3},
    {4'd1,  4'd0, 6'b001000, 16'd4},
    {4'd1,  4'd0, 6'b001001, 16'd3},
    {4'd3,  4'd0, 6'b011001, 16'd3},
    {4'd3,  4'd0, 6'b011011, 16'd4},
    {4'd3,  4'd0, 6'b001011, 16'd4},
    {4'd4,  4'd0, 6'b001111, 16'd4},
    {4'd4,  4'd0, 6'b001110, 16'd4},
    {4'd4,  4'd0, 6'b001010, 16'd4},
    {4'd4,  4'd0, 6'b001000, 16'd3},
    {4'd4,  4'd0, 6'b000000, 16'd3},
    {4'd4,  4'd0, 6'b000010, 16'd3},
    {4'd4,  4'd0, 6'b000110, 16'd3},
    {4'd4,  4'd0, 6'b000111, 16'd4},
    {4'd2,  4'd0, 6'b100111, 16'd4},
    {4'd2,  4'd0, 6'b100101, 16'd4},
    {4'd2,  4'd0, 6'b100111, 16'd3},
    {4'd2,  4'd0, 6'b100110, 16'd3},
    {4'd2,  4'd0, 6'b100100, 16'd3},
    {4'd2,  4'd0, 6'b100110, 16'd4},
    {4'd3,  4'd0, 6'b110100, 16'd4},
    {4'd3,  4'd0, 6'b110110, 16'd3},
    {4'd3,  4'd0, 6'b110101, 16'd3},
    {4'd3,  4'd0, 6'b110111, 16'd4}
  };

  function automatic string rtag(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic set_ab(input logic a, input logic b);
    @(negedge clk);
    trk_a = a;
    trk_b = b;
    settle();
  endtask

  task automatic do_load(input logic [W-1:0] v);
    @(negedge clk);
    load_val = v;
    load_en  = 1'b1;
    @(negedge clk);
    load_en  = 1'b0;
    settle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trk_a = 1'b0; trk_b = 1'b0; gate_in = 1'b0; gate_pol = 1'b1;
    mode_updn = 1'b0; dir_rev = 1'b0; rst_src_en = 1'b0; load_en = 1'b0;
    clr = 1'b0; load_val = '0;
    repeat (3) @(negedge clk);
    check("R12 count in reset", count, '0);
    check("R12 flags in reset", {14'd0, ovf_flag, unf_flag}, '0);
    check("R12 err in reset", {15'd0, quad_err}, '0);
    rst_n = 1'b1;
    settle();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {mode_updn, dir_rev, gate_pol, gate_in, trk_a, trk_b} = VEC[i][21:16];
      settle();
      check(rtag(VEC[i][29:26]), count, VEC[i][15:0]);
    end

    // R5: illegal quadrature transition from 11 to 00
    @(negedge clk);
    mode_updn = 1'b0; dir_rev = 1'b0;
    settle();
    err_pulses = 0;
    set_ab(1'b0, 1'b0);
    check("R5 count on illegal step", count, 16'd4);
    check("R5 error pulse count", 16'(err_pulses), 16'd1);
    // R5: same double change in pulse mode is a legal down step, no error
    @(negedge clk);
    mode_updn = 1'b1;
    settle();
    set_ab(1'b1, 1'b1);
    check("R5 pulse-mode count", count, 16'd3);
    check("R5 no error in pulse mode", 16'(err_pulses), 16'd1);

    // R12: latency of a track change (11 -> 01 is up in quadrature)
    @(negedge clk);
    mode_updn = 1'b0;
    settle();
    @(negedge clk);
    trk_a = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R12 before third edge", count, 16'd3);
    @(posedge clk); @(negedge clk);
    check("R12 at third edge", count, 16'd4);
    settle();

    // R11: clear beats load, then load alone
    @(negedge clk);
    load_val = 16'd1234; load_en = 1'b1; clr = 1'b1;
    @(negedge clk);
    load_en = 1'b0; clr = 1'b0;
    check("R11 clear priority", count, 16'd0);
    do_load(16'd1234);
    check("R11 load value", count, 16'd1234);
    do_load(16'hFFFF);
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    settle();
    check("R11 clear sets no flag", {14'd0, ovf_flag, unf_flag}, '0);

    // R6/R7: overflow wrap and hysteresis (state is 01, step to 00 is up)
    do_load(16'hFFFF);
    set_ab(1'b0, 1'b0);
    check("R6 wrap count", count, 16'd0);
    check("R6 overflow set", {15'd0, ovf_flag}, 16'd1);
    check("R6 no underflow", {15'd0, unf_flag}, 16'd0);
    do_load(16'd21845);
    check("R6 overflow held at third", {15'd0, ovf_flag}, 16'd1);
    do_load(16'd21846);
    check("R7 overflow cleared", {15'd0, ovf_flag}, 16'd0);

    // R8/R9: underflow wrap and hysteresis (00 -> 01 is down)
    do_load(16'd0);
    set_ab(1'b0, 1'b1);
    check("R8 wrap count", count, 16'hFFFF);
    check("R8 underflow set", {15'd0, unf_flag}, 16'd1);
    do_load(16'd43690);
    check("R8 underflow held at two thirds", {15'd0, unf_flag}, 16'd1);
    do_load(16'd43689);
    check("R9 underflow cleared", {15'd0, unf_flag}, 16'd0);

    // R10: reset source enabled blocks and clears the flags
    do_load(16'hFFFF);
    @(negedge clk); rst_src_en = 1'b1;
    set_ab(1'b0, 1'b0);
    check("R10 wrap count", count, 16'd0);
    check("R10 overflow blocked", {15'd0, ovf_flag}, 16'd0);
    @(negedge clk); rst_src_en = 1'b0;
    set_ab(1'b0, 1'b1);
    check("R10 underflow set when enabled off", {15'd0, unf_flag}, 16'd1);
    @(negedge clk); rst_src_en = 1'b1;
    settle();
    check("R10 underflow forced low", {15'd0, unf_flag}, 16'd0);
    @(negedge clk); rst_src_en = 1'b0;
    settle();
    check("R10 underflow stays low", {15'd0, unf_flag}, 16'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule